// File: doc/BRIEF.md
# Protected Glitch-Free Clock Prescaler

This block derives a system clock from a fast source clock by a power-of-two ratio that software picks through one control register. The ratio cannot be changed by a single stray write. Software first writes a fixed key value, which arms the register. It must then write the new select value within a short window of bus cycles. Writes outside that sequence leave the setting as it was. The same register reads back the stored select value and shows whether the register is currently armed.

A new setting does not pass through any in-between rate, and it never produces a runt pulse. The select value crosses from the bus clock domain into the source domain through a toggle synchronizer. There it waits for the next falling edge of the old system clock. At that edge a free-running source-domain counter is cleared and the new ratio takes effect, so the first low phase already has the new length.

A second output, the converter clock, is divided further by 8, 4, 2 or 1. The two low bits of the select value pick this extra factor, so the converter clock follows the system setting. Both outputs come straight from flip-flops clocked by the source clock.

Top module: `prot_clk_prescaler`

## Requirements
- R1: After reset the select value is 3, the arm flag is clear, and the readback word is 0x03. The readback word has the arm flag in bit 7, zeros in bits 6..4, and the stored select value in bits 3..0.
- R2: A write of exactly 0x80 sets the arm flag, which then shows as bit 7 of the readback word. Any other write with bit 7 set leaves the arm flag clear.
- R3: While the block is armed, a write with bit 7 clear on any of the first four bus clock edges after the arming edge loads the select value and clears the arm flag. After four such edges with no write, the arm flag clears by itself, and a later write changes nothing.
- R4: A write made while the block is not armed changes neither the stored select value nor the output rate.
- R5: A select value above 8 is stored and applied as 8.
- R6: With select value N, the system clock has a period of 2^(N+1) source clock periods and a 50% duty cycle.
- R7: The converter clock period is the system clock period times 2^(3 - S), where S is bits 1..0 of the stored select value.
- R8: A new setting takes effect only at a falling edge of the old system clock. The next low phase is already half the new period. Both outputs run at the new rate no later than T1 + T2 + 4 source periods after the accepting bus edge, where T1 is the old system period and T2 the new one.
- R9: Neither output ever has a high or low phase shorter than one source clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_en | input | 1 | Write strobe, sampled on bus_clk |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Readback: arm flag in bit 7, select value in bits 3..0 |
| src_clk | input | 1 | Undivided source clock |
| sys_clk_o | output | 1 | Divided system clock |
| conv_clk_o | output | 1 | Converter clock, further divided from the system clock |

## Verification
A stuck or miscounted unlock window changes bit 7 of the readback on the very next bus edge. It can also let a late write alter bits 3..0, which the bench reads back right after that write. A wrong active ratio or a misplaced counter clear in the source domain shows up as a wrong rising-edge interval on either clock output. The bench measures these intervals only after the settling bound of R8, so a slow switch is also caught. A runt pulse is caught by a pulse-width monitor that runs over every phase of both outputs for the whole run.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
   localparam int CTRL_W = 8;
   localparam int SEL_W  = 4;
   localparam int CE_POS = 7;

   typedef struct packed {
      logic             ce;
      logic [2:0]       rsvd;
      logic [SEL_W-1:0] sel;
   } ctrl_view_t;

   localparam logic [CTRL_W-1:0] UNLOCK_KEY = CTRL_W'(1) << CE_POS;
endpackage

// File: rtl/cdp_ctrl_reg.sv
module cdp_ctrl_reg
   import cdp_pkg::*;
#(
   parameter int MAX_N      = 8,
   parameter int UNLOCK_WIN = 4,
   parameter int RST_SEL    = 3
) (
   input  logic              bus_clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output logic [SEL_W-1:0]  sel_o,
   output logic              acc_tgl_o,
   output logic [CTRL_W-1:0] rd_data_o
);
   localparam int WCW = $clog2(UNLOCK_WIN + 1);

   logic             armed_q;
   logic [WCW-1:0]   win_q;
   logic [SEL_W-1:0] sel_q;
   logic             tgl_q;
   logic             key_hit;
   logic             accept;
   logic [SEL_W-1:0] sel_clamped;
   ctrl_view_t       view;

   assign key_hit     = wr_en && (wr_data == UNLOCK_KEY);
   assign accept      = wr_en && armed_q && !wr_data[CE_POS];
   assign sel_clamped = (wr_data[SEL_W-1:0] > SEL_W'(MAX_N)) ? SEL_W'(MAX_N)
                                                             : wr_data[SEL_W-1:0];

   always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         win_q   <= '0;
         sel_q   <= SEL_W'(RST_SEL);
         tgl_q   <= 1'b0;
      end else if (key_hit) begin
         armed_q <= 1'b1;
         win_q   <= '0;
      end else if (accept) begin
         armed_q <= 1'b0;
         sel_q   <= sel_clamped;
         tgl_q   <= ~tgl_q;
      end else if (armed_q) begin
         if (win_q == WCW'(UNLOCK_WIN - 1)) begin
            armed_q <= 1'b0;
         end else begin
            win_q <= win_q + WCW'(1);
         end
      end
   end

   always_comb begin
      view      = '0;
      view.ce   = armed_q;
      view.sel  = sel_q;
      rd_data_o = view;
   end

   assign sel_o     = sel_q;
   assign acc_tgl_o = tgl_q;

   // R2: arming only follows the exact key write
   a_r2_arm_needs_key: assert property (@(posedge bus_clk) disable iff (!rst_n)
      $rose(armed_q) |-> $past(wr_en && (wr_data == UNLOCK_KEY)));

   // R3/R4: the stored select changes only through an armed write with bit 7 clear
   a_r3_sel_only_when_armed: assert property (@(posedge bus_clk) disable iff (!rst_n)
      !$stable(sel_q) |-> $past(armed_q && wr_en && !wr_data[CE_POS]));

   // R5: stored value never exceeds the largest ratio
   a_r5_sel_clamped: assert property (@(posedge bus_clk) disable iff (!rst_n)
      sel_q <= SEL_W'(MAX_N));
endmodule

// File: rtl/cdp_req_sync.sv
module cdp_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl_i,
   output logic pulse_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= tgl_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign pulse_o = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/cdp_div_core.sv
module cdp_div_core
   import cdp_pkg::*;
#(
   parameter int MAX_N     = 8,
   parameter int CONV_BITS = 2,
   parameter int RST_SEL   = 3
) (
   input  logic             src_clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             sys_o,
   output logic             conv_o
);
   localparam int CONV_SH = (1 << CONV_BITS) - 1;
   localparam int CW      = MAX_N + CONV_SH + 1;
   localparam int IW      = $clog2(CW) + 1;

   logic [CW-1:0]    cnt_q, cnt_nx;
   logic [SEL_W-1:0] n_q, n_nx;
   logic [SEL_W-1:0] pend_n_q;
   logic             pend_q;
   logic             wrap;
   logic             take;
   logic [CW-1:0]    phase_mask;
   logic             sys_q;
   logic             conv_q;
   logic             conv_bit;

   assign phase_mask = (CW'(2) << n_q) - CW'(1);
   assign wrap       = (cnt_q & phase_mask) == phase_mask;
   assign take       = pend_q && wrap;

   always_comb begin
      if (take) begin
         cnt_nx = '0;
         n_nx   = pend_n_q;
      end else begin
         cnt_nx = cnt_q + CW'(1);
         n_nx   = n_q;
      end
   end

   generate
      if (CONV_BITS == 0) begin : g_conv_same
         assign conv_bit = cnt_nx[n_nx];
      end else begin : g_conv_shift
         logic [IW-1:0] conv_idx;
         assign conv_idx = IW'(n_nx) + IW'(CONV_SH) - IW'(n_nx[CONV_BITS-1:0]);
         assign conv_bit = cnt_nx[conv_idx];
      end
   endgenerate

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= 1'b0;
         pend_n_q <= SEL_W'(RST_SEL);
      end else if (req_i) begin
         pend_q   <= 1'b1;
         pend_n_q <= sel_i;
      end else if (take) begin
         pend_q   <= 1'b0;
      end
   end

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         n_q    <= SEL_W'(RST_SEL);
         sys_q  <= 1'b0;
         conv_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_nx;
         n_q    <= n_nx;
         sys_q  <= cnt_nx[n_nx];
         conv_q <= conv_bit;
      end
   end

   assign sys_o  = sys_q;
   assign conv_o = conv_q;

   // R8: a new ratio is applied only at a falling edge of the old clock
   a_r8_switch_at_fall: assert property (@(posedge src_clk) disable iff (!rst_n)
      !$stable(n_q) |-> (!sys_q && $past(sys_q) && !conv_q));

   // R6: without a switch the output toggles only on a half-period boundary
   a_r6_half_period_edge: assert property (@(posedge src_clk) disable iff (!rst_n)
      (!$stable(sys_q) && $stable(n_q)) |-> ((cnt_q & (phase_mask >> 1)) == '0));

   // R5: the active ratio stays in range
   a_r5_active_in_range: assert property (@(posedge src_clk) disable iff (!rst_n)
      n_q <= SEL_W'(MAX_N));
endmodule

// File: rtl/prot_clk_prescaler.sv
module prot_clk_prescaler
   import cdp_pkg::*;
#(
   parameter int MAX_N       = 8,
   parameter int CONV_BITS   = 2,
   parameter int UNLOCK_WIN  = 4,
   parameter int SYNC_STAGES = 2,
   parameter int RST_SEL     = 3
) (
   input  logic              bus_clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output logic [CTRL_W-1:0] rd_data,
   input  logic              src_clk,
   output logic              sys_clk_o,
   output logic              conv_clk_o
);
   generate
      if (MAX_N < 1 || MAX_N >= (1 << SEL_W)) begin : g_bad_max
         $error("MAX_N out of range for the select field");
      end
      if (RST_SEL > MAX_N) begin : g_bad_rst
         $error("RST_SEL above MAX_N");
      end
      if (UNLOCK_WIN < 1) begin : g_bad_win
         $error("UNLOCK_WIN must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CONV_BITS > SEL_W) begin : g_bad_conv
         $error("CONV_BITS wider than the select field");
      end
   endgenerate

   logic [SEL_W-1:0] sel_bus;
   logic             acc_tgl;
   logic             req_pulse;

   cdp_ctrl_reg #(
      .MAX_N      (MAX_N),
      .UNLOCK_WIN (UNLOCK_WIN),
      .RST_SEL    (RST_SEL)
   ) u_ctrl (
      .bus_clk   (bus_clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .sel_o     (sel_bus),
      .acc_tgl_o (acc_tgl),
      .rd_data_o (rd_data)
   );

   cdp_req_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (src_clk),
      .rst_n   (rst_n),
      .tgl_i   (acc_tgl),
      .pulse_o (req_pulse)
   );

   cdp_div_core #(
      .MAX_N     (MAX_N),
      .CONV_BITS (CONV_BITS),
      .RST_SEL   (RST_SEL)
   ) u_core (
      .src_clk (src_clk),
      .rst_n   (rst_n),
      .req_i   (req_pulse),
      .sel_i   (sel_bus),
      .sys_o   (sys_clk_o),
      .conv_o  (conv_clk_o)
   );
endmodule

// File: tb/prot_clk_prescaler_tb_top.sv
`timescale 1ns/1ps
module prot_clk_prescaler_tb_top;
   localparam real TCLK = 5.0;
   localparam int  NVEC = 9;
   localparam int  VEC_W [NVEC] = '{0, 1, 3, 5, 8, 4, 15, 7, 0};
   localparam int  VEC_N [NVEC] = '{0, 1, 3, 5, 8, 4,  8, 7, 0};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       sys_clk_o, conv_clk_o;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;
   realtime last_sys = 0, last_conv = 0;
   real min_sys = 1.0e9, min_conv = 1.0e9;

   always #(TCLK / 2.0) clk = ~clk;

   prot_clk_prescaler dut_i (
      .bus_clk    (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .src_clk    (clk),
      .sys_clk_o  (sys_clk_o),
      .conv_clk_o (conv_clk_o)
   );

   // R9 pulse-width monitors
   always @(sys_clk_o) begin
      if (rst_n && last_sys > 0 && ($realtime - last_sys) < min_sys) min_sys = $realtime - last_sys;
      if (rst_n) last_sys = $realtime;
   end
   always @(conv_clk_o) begin
      if (rst_n && last_conv > 0 && ($realtime - last_conv) < min_conv) min_conv = $realtime - last_conv;
      if (rst_n) last_conv = $realtime;
   end

   task automatic check_int(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic check_real(input string req, input real act, input real exp);
      n_chk++;
      if (act < exp - 0.01 || act > exp + 0.01) begin
         n_bad++;
         $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] v);
      wr_en = 1'b1;
      wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = 8'h00;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic period_sys(output real p);
      realtime t0;
      @(posedge sys_clk_o); t0 = $realtime;
      @(posedge sys_clk_o); p = $realtime - t0;
      @(negedge clk);
   endtask

   task automatic period_conv(output real p);
      realtime t0;
      @(posedge conv_clk_o); t0 = $realtime;
      @(posedge conv_clk_o); p = $realtime - t0;
      @(negedge clk);
   endtask

   function automatic real exp_sys(input int n);
      return TCLK * real'(1 << (n + 1));
   endfunction

   function automatic real exp_conv(input int n);
      return TCLK * real'(1 << (n + 4 - (n % 4)));
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(TCLK * 190000.0);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      real p;
      int  prev_n;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      check_int("R1 reset readback", rd_data, 8'h03);
      period_sys(p);  check_real("R6 reset sys period", p, exp_sys(3));
      period_conv(p); check_real("R7 reset conv period", p, exp_conv(3));

      // R2 arming, R3 auto clear
      wr_reg(8'h80);  check_int("R2 armed flag", rd_data, 8'h83);
      idle(3);        check_int("R3 still armed in window", rd_data, 8'h83);
      idle(1);        check_int("R3 arm self-clear", rd_data, 8'h03);

      // R2 wrong key does not arm; R4 following write ignored
      wr_reg(8'h81);  check_int("R2 impure key no arm", rd_data, 8'h03);
      wr_reg(8'h05);  check_int("R4 write after bad key ignored", rd_data, 8'h03);
      wr_reg(8'h01);  check_int("R4 unarmed write ignored", rd_data, 8'h03);

      // R3 late write (fifth edge) ignored
      wr_reg(8'h80);
      idle(4);
      wr_reg(8'h01);  check_int("R3 late write ignored", rd_data, 8'h03);
      idle(40);
      period_sys(p);  check_real("R3 rate unchanged after late write", p, exp_sys(3));

      // R3 write on fourth edge accepted
      wr_reg(8'h80);
      idle(3);
      wr_reg(8'h02);  check_int("R3 fourth-edge write accepted", rd_data, 8'h02);
      idle(4 + (1 << 4) + (1 << 3));
      period_sys(p);  check_real("R8 sys rate within bound 3->2", p, exp_sys(2));
      prev_n = 2;

      // table of settings: R5 clamp, R6 and R7 rates, R8 bound
      for (int i = 0; i < NVEC; i++) begin
         wr_reg(8'h80);
         wr_reg(8'(VEC_W[i]));
         check_int($sformatf("R5 readback vec %0d", i), rd_data, VEC_N[i]);
         idle(4 + (1 << (prev_n + 1)) + (1 << (VEC_N[i] + 1)));
         period_sys(p);
         check_real($sformatf("R6 R8 sys period vec %0d", i), p, exp_sys(VEC_N[i]));
         period_conv(p);
         check_real($sformatf("R7 conv period vec %0d", i), p, exp_conv(VEC_N[i]));
         prev_n = VEC_N[i];
      end

      // R9 minimum phase width over the run
      check_real("R9 sys min phase", (min_sys >= TCLK) ? 1.0 : min_sys, 1.0);
      check_real("R9 conv min phase", (min_conv >= TCLK) ? 1.0 : min_conv, 1.0);

      finish_run();
   end
endmodule